// File: doc/BRIEF.md
# TDM Serial Stream Port

This block connects a set of serial time-division-multiplexed data lines on a backplane bus to parallel byte traffic inside the chip. A system clock sixteen times faster than the bus bit clock samples the bus bit clock and the frame pulse as ordinary inputs. One shared timer finds each rising edge of the bus clock, counts system-clock ticks inside every bus bit period and counts bus bit periods inside the 1024-period frame. Every stream lane decodes that shared position at its own rate (8, 4 or 2 Mb/s), giving it a slot number, a bit position and a tick offset within the current bit.

On the receive side each lane samples its line once per bit, at a chosen fraction of the bit period. When the last bit of a slot has been taken, the lane presents the byte with a one-cycle strobe and the slot index. On the transmit side each lane asks for the byte of the next slot when a slot begins. It shifts the byte out most significant bit first and drives an output enable that follows the drive flag given with the byte. The enable can be released a few ticks before the slot's closing edge, or on that edge.

Top module: `tdm_stream_port`

## Requirements
- R1: After reset, and until a frame pulse has been seen high at a detected rising edge of the bus clock, rx_valid, tx_req and tx_oe all stay low.
- R2: A frame pulse seen high at a detected bus-clock rising edge starts bit 7 of slot 0 on every stream. The frame holds 1024 bus bit periods, and rx_slot reports the slot a received byte belongs to.
- R3: rate_cfg field i (bits 2i+1:2i) sets stream i: 00 and 11 give one bus period per bit and 128 slots, 01 gives two periods per bit and 64 slots, and 10 gives four periods per bit and 32 slots.
- R4: Streams with an index at or above LOW_RATE_STREAMS always run at one bus period per bit, whatever their rate_cfg field holds.
- R5: Within a slot, bits are received and transmitted most significant bit first.
- R6: The tick offset counts system clocks from the cycle after the rising edge is detected, over a bit of P = 16·k ticks, where k is the number of bus periods per bit. sample_cfg 00 and 11 sample at offset 12·k, 01 samples at 8·k, and 10 samples at P−1.
- R7: rx_valid pulses for one cycle, in the cycle after the last bit of a slot is sampled, with the byte on rx_byte and its slot on rx_slot.
- R8: tx_req is high for the one cycle at offset 0 of the first bit of each slot. tx_req_slot then gives the next slot number, wrapping to 0 after the last slot, and tx_byte and tx_drive are captured in that cycle.
- R9: The byte captured for a slot is driven on tx_out during that slot. Each bit appears one cycle after its bit starts and holds for the whole bit.
- R10: With tz_cfg other than 01, tx_oe follows the captured drive flag for the whole slot and changes one cycle after the slot starts. The first slot after synchronisation is never driven.
- R11: With tz_cfg 01, tx_oe of a driven slot drops in the cycle after offset P−EARLY_TICKS of the slot's last bit, before the closing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 16 ticks per bus bit period |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_clk_in | input | 1 | Sampled bus bit clock |
| frame_in | input | 1 | Sampled frame pulse |
| rate_cfg | input | 2×N_STREAMS | Per-stream rate code |
| sample_cfg | input | 2 | Receive sample point code |
| tz_cfg | input | 2 | Transmit release code |
| rx_in | input | N_STREAMS | Serial receive lines |
| rx_valid | output | N_STREAMS | Received byte strobe per stream |
| rx_byte | output | 8×N_STREAMS | Received byte per stream |
| rx_slot | output | 7×N_STREAMS | Slot of the received byte |
| tx_req | output | N_STREAMS | Next-slot byte request per stream |
| tx_req_slot | output | 7×N_STREAMS | Slot number being requested |
| tx_byte | input | 8×N_STREAMS | Byte supplied on request |
| tx_drive | input | N_STREAMS | Drive flag supplied on request |
| tx_out | output | N_STREAMS | Serial transmit lines |
| tx_oe | output | N_STREAMS | Output enable per stream |

## Verification
The sample point is the hardest thing to observe from the ports, because a line that holds its bit for the whole period gives the right byte at any sample offset. The stimulus therefore drives the true bit only in the single tick where the requirement says sampling happens, and the inverted bit in every other tick, so a sample taken one tick off corrupts the byte. Each run also crosses the frame wrap, so the request for slot 0 made during the last slot can be followed through to the next frame's first slot at every rate.

// File: rtl/tdm_port_pkg.sv
// Package: configuration codes and decode helpers shared by the TDM port.
// Assumes rate codes pick 1, 2 or 4 bus periods per bit.
package tdm_port_pkg;

    typedef enum logic [1:0] {
        RATE_FULL    = 2'b00,
        RATE_HALF    = 2'b01,
        RATE_QUARTER = 2'b10,
        RATE_SPARE   = 2'b11
    } rate_code_e;

    typedef enum logic [1:0] {
        SMP_THREE_Q = 2'b00,
        SMP_MID     = 2'b01,
        SMP_END     = 2'b10,
        SMP_SPARE   = 2'b11
    } sample_code_e;

    typedef enum logic [1:0] {
        REL_ON_EDGE = 2'b00,
        REL_EARLY   = 2'b01,
        REL_SPARE2  = 2'b10,
        REL_SPARE3  = 2'b11
    } release_code_e;

    // Map a rate code to log2 of bus periods per bit.
    function automatic logic [1:0] rate_to_shift(input logic [1:0] code);
        case (code)
            RATE_HALF:    return 2'd1;
            RATE_QUARTER: return 2'd2;
            default:      return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/tdm_bit_timer.sv
// Module: shared bus timer. Detects bus-clock rising edges, counts ticks
// inside each bus period and bus periods inside the frame. Assumes the
// system clock oversamples the bus clock so that ticks never exceed 2^TICK_W.
module tdm_bit_timer #(
    parameter int TICK_W = 4,
    parameter int PC_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk_in,
    input  logic              frame_in,
    output logic [PC_W-1:0]   pc,
    output logic [TICK_W-1:0] ph,
    output logic              synced
);

    logic bus_d;
    logic rise;

    // Edge detector on the sampled bus clock.
    assign rise = bus_clk_in & ~bus_d;

    // Period/tick counters, frame alignment and sync flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_d  <= 1'b0;
            ph     <= '0;
            pc     <= '0;
            synced <= 1'b0;
        end else begin
            bus_d <= bus_clk_in;
            if (rise) begin
                ph <= '0;
                if (frame_in) begin
                    pc     <= '0;
                    synced <= 1'b1;
                end else begin
                    pc <= pc + 1'b1;
                end
            end else if (ph != '1) begin
                ph <= ph + 1'b1;
            end
        end
    end

    AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && frame_in) |=> (pc == '0 && ph == '0 && synced)); // R2

endmodule

// File: rtl/tdm_lane_pos.sv
// Module: per-lane position decode. Turns the shared period/tick count into
// slot, bit and tick offset at the lane's rate. Purely combinational.
// Assumes shift is at most MAX_SHIFT.
module tdm_lane_pos #(
    parameter int TICK_W    = 4,
    parameter int PC_W      = 10,
    parameter int MAX_SHIFT = 2,
    localparam int OFF_W    = TICK_W + MAX_SHIFT,
    localparam int SLOT_W   = PC_W - 3
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [TICK_W-1:0] ph,
    input  logic [1:0]        shift,
    output logic [SLOT_W-1:0] slot,
    output logic [2:0]        bsel,
    output logic [OFF_W-1:0]  off,
    output logic [OFF_W-1:0]  span
);

    logic [PC_W-1:0]  bitnum;
    logic [OFF_W-1:0] off_raw;

    // Decode bit index, slot and tick offset for the lane's rate.
    always_comb begin
        bitnum  = pc >> shift;
        slot    = bitnum[PC_W-1:3];
        bsel    = bitnum[2:0];
        span    = ~({OFF_W{1'b1}} << (TICK_W + int'(shift)));
        off_raw = {pc[MAX_SHIFT-1:0], ph};
        off     = off_raw & span;
    end

endmodule

// File: rtl/tdm_rx_lane.sv
// Module: receive lane. Samples the line once per bit at the chosen offset
// and reports each finished slot byte with a one-cycle strobe.
// Assumes configuration is held steady while synced.
module tdm_rx_lane #(
    parameter int TICK_W    = 4,
    parameter int PC_W      = 10,
    parameter int MAX_SHIFT = 2,
    localparam int OFF_W    = TICK_W + MAX_SHIFT,
    localparam int SLOT_W   = PC_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              synced,
    input  logic [PC_W-1:0]   pc,
    input  logic [TICK_W-1:0] ph,
    input  logic [1:0]        shift,
    input  logic [1:0]        smp_code,
    input  logic              rx_in,
    output logic              rx_valid,
    output logic [7:0]        rx_byte,
    output logic [SLOT_W-1:0] rx_slot
);
    import tdm_port_pkg::*;

    logic [SLOT_W-1:0] slot;
    logic [2:0]        bsel;
    logic [OFF_W-1:0]  off;
    logic [OFF_W-1:0]  span;
    logic [OFF_W:0]    plen;
    logic [OFF_W-1:0]  samp;
    logic              hit;
    logic [6:0]        sr;

    tdm_lane_pos #(.TICK_W(TICK_W), .PC_W(PC_W), .MAX_SHIFT(MAX_SHIFT)) u_pos (
        .pc(pc), .ph(ph), .shift(shift),
        .slot(slot), .bsel(bsel), .off(off), .span(span)
    );

    // Select the sample offset inside the bit.
    always_comb begin
        plen = {1'b0, span} + 1'b1;
        case (smp_code)
            SMP_MID: samp = OFF_W'(plen >> 1);
            SMP_END: samp = span;
            default: samp = OFF_W'(plen - (plen >> 2));
        endcase
        hit = synced && (off == samp);
    end

    // Shift in sampled bits and publish the byte after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
            rx_slot  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (hit) begin
                sr <= {sr[5:0], rx_in};
                if (bsel == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {sr, rx_in};
                    rx_slot  <= slot;
                end
            end
        end
    end

    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7
    AST_RX_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_slot <= (SLOT_W'({SLOT_W{1'b1}}) >> shift))); // R3
    AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> !rx_valid); // R1

endmodule

// File: rtl/tdm_tx_lane.sv
// Module: transmit lane. Requests the next slot's byte at each slot start,
// shifts the current byte out MSB first and times the output enable.
// Assumes the requester answers in the same cycle as tx_req.
module tdm_tx_lane #(
    parameter int TICK_W      = 4,
    parameter int PC_W        = 10,
    parameter int MAX_SHIFT   = 2,
    parameter int EARLY_TICKS = 4,
    localparam int OFF_W      = TICK_W + MAX_SHIFT,
    localparam int SLOT_W     = PC_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              synced,
    input  logic [PC_W-1:0]   pc,
    input  logic [TICK_W-1:0] ph,
    input  logic [1:0]        shift,
    input  logic [1:0]        tz_code,
    input  logic [7:0]        tx_byte,
    input  logic              tx_drive,
    output logic              tx_req,
    output logic [SLOT_W-1:0] tx_req_slot,
    output logic              tx_out,
    output logic              tx_oe
);
    import tdm_port_pkg::*;

    logic [SLOT_W-1:0] slot;
    logic [2:0]        bsel;
    logic [OFF_W-1:0]  off;
    logic [OFF_W-1:0]  span;
    logic [SLOT_W-1:0] slots_m1;
    logic              slot_start;
    logic              bit_start;
    logic              early_cut;
    logic              early_zone;
    logic [7:0]        pend_byte;
    logic              pend_drv;
    logic [7:0]        sh;

    tdm_lane_pos #(.TICK_W(TICK_W), .PC_W(PC_W), .MAX_SHIFT(MAX_SHIFT)) u_pos (
        .pc(pc), .ph(ph), .shift(shift),
        .slot(slot), .bsel(bsel), .off(off), .span(span)
    );

    // Slot/bit boundary strobes, next-slot number and early release point.
    always_comb begin
        slots_m1    = SLOT_W'({SLOT_W{1'b1}}) >> shift;
        bit_start   = synced && (off == '0);
        slot_start  = bit_start && (bsel == 3'd0);
        tx_req_slot = (slot == slots_m1) ? '0 : slot + 1'b1;
        early_cut   = synced && (tz_code == REL_EARLY) && (bsel == 3'd7)
                      && (off == span - OFF_W'(EARLY_TICKS - 1));
        early_zone  = synced && (tz_code == REL_EARLY) && (bsel == 3'd7)
                      && (off > span - OFF_W'(EARLY_TICKS - 1));
    end

    assign tx_req = slot_start;
    assign tx_out = sh[7];

    // Capture the requested byte, load and shift the output, time the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_byte <= '0;
            pend_drv  <= 1'b0;
            sh        <= '0;
            tx_oe     <= 1'b0;
        end else begin
            if (slot_start) begin
                sh        <= pend_byte;
                tx_oe     <= pend_drv;
                pend_byte <= tx_byte;
                pend_drv  <= tx_drive;
            end else if (bit_start) begin
                sh <= {sh[6:0], 1'b0};
            end
            if (early_cut) begin
                tx_oe <= 1'b0;
            end
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_start |=> $stable(tx_out)); // R9
    AST_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        early_zone |-> !tx_oe); // R11
    AST_REQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (tx_req_slot <= slots_m1)); // R8
    AST_OE_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> !tx_oe); // R1

endmodule

// File: rtl/tdm_stream_port.sv
// Module: TDM serial stream port top. One shared bus timer feeds a receive
// and a transmit lane per stream. Streams at or above LOW_RATE_STREAMS are
// held at the full bus rate. Assumes the configuration changes only in reset.
module tdm_stream_port #(
    parameter int N_STREAMS        = 4,
    parameter int LOW_RATE_STREAMS = 2,
    parameter int TICK_W           = 4,
    parameter int PC_W             = 10,
    parameter int EARLY_TICKS      = 4,
    localparam int SLOT_W          = PC_W - 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_clk_in,
    input  logic                          frame_in,
    input  logic [2*N_STREAMS-1:0]        rate_cfg,
    input  logic [1:0]                    sample_cfg,
    input  logic [1:0]                    tz_cfg,
    input  logic [N_STREAMS-1:0]          rx_in,
    output logic [N_STREAMS-1:0]          rx_valid,
    output logic [8*N_STREAMS-1:0]        rx_byte,
    output logic [SLOT_W*N_STREAMS-1:0]   rx_slot,
    output logic [N_STREAMS-1:0]          tx_req,
    output logic [SLOT_W*N_STREAMS-1:0]   tx_req_slot,
    input  logic [8*N_STREAMS-1:0]        tx_byte,
    input  logic [N_STREAMS-1:0]          tx_drive,
    output logic [N_STREAMS-1:0]          tx_out,
    output logic [N_STREAMS-1:0]          tx_oe
);
    import tdm_port_pkg::*;

    localparam int MAX_SHIFT = 2;

    logic [PC_W-1:0]   pc;
    logic [TICK_W-1:0] ph;
    logic              synced;

    tdm_bit_timer #(.TICK_W(TICK_W), .PC_W(PC_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .bus_clk_in(bus_clk_in), .frame_in(frame_in),
        .pc(pc), .ph(ph), .synced(synced)
    );

    for (genvar gi = 0; gi < N_STREAMS; gi++) begin : g_lane
        logic [1:0] lane_shift;

        // Rate selection; upper streams are pinned to the full rate.
        if (gi < LOW_RATE_STREAMS) begin : g_multi
            assign lane_shift = rate_to_shift(rate_cfg[2*gi +: 2]);
        end else begin : g_fixed
            assign lane_shift = 2'd0;
        end

        tdm_rx_lane #(.TICK_W(TICK_W), .PC_W(PC_W), .MAX_SHIFT(MAX_SHIFT)) u_rx (
            .clk(clk), .rst_n(rst_n), .synced(synced), .pc(pc), .ph(ph),
            .shift(lane_shift), .smp_code(sample_cfg), .rx_in(rx_in[gi]),
            .rx_valid(rx_valid[gi]), .rx_byte(rx_byte[8*gi +: 8]),
            .rx_slot(rx_slot[SLOT_W*gi +: SLOT_W])
        );

        tdm_tx_lane #(.TICK_W(TICK_W), .PC_W(PC_W), .MAX_SHIFT(MAX_SHIFT),
                      .EARLY_TICKS(EARLY_TICKS)) u_tx (
            .clk(clk), .rst_n(rst_n), .synced(synced), .pc(pc), .ph(ph),
            .shift(lane_shift), .tz_code(tz_cfg),
            .tx_byte(tx_byte[8*gi +: 8]), .tx_drive(tx_drive[gi]),
            .tx_req(tx_req[gi]), .tx_req_slot(tx_req_slot[SLOT_W*gi +: SLOT_W]),
            .tx_out(tx_out[gi]), .tx_oe(tx_oe[gi])
        );

        if (gi >= LOW_RATE_STREAMS) begin : g_fixed_chk
            AST_FIXED_RATE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                tx_req[gi] |-> (ph == '0 && pc[2:0] == 3'd0)); // R4
        end
    end

endmodule

// File: tb/sim_tdm_stream_port.sv
// Bench: random line data and bytes with directed configuration corners,
// checked cycle by cycle against a model derived from the requirements.
module sim_tdm_stream_port;
    localparam int NS    = 4;
    localparam int LOWN  = 2;
    localparam int FRAME = 16384;
    localparam int EARLY = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic            bus_clk_in, frame_in;
    logic [2*NS-1:0] rate_cfg;
    logic [1:0]      sample_cfg, tz_cfg;
    logic [NS-1:0]   rx_in, rx_valid, tx_req, tx_drive, tx_out, tx_oe;
    logic [8*NS-1:0] rx_byte, tx_byte;
    logic [7*NS-1:0] rx_slot, tx_req_slot;

    tdm_stream_port #(.N_STREAMS(NS), .LOW_RATE_STREAMS(LOWN)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_clk_in(bus_clk_in), .frame_in(frame_in),
        .rate_cfg(rate_cfg), .sample_cfg(sample_cfg), .tz_cfg(tz_cfg),
        .rx_in(rx_in), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_slot(rx_slot),
        .tx_req(tx_req), .tx_req_slot(tx_req_slot), .tx_byte(tx_byte),
        .tx_drive(tx_drive), .tx_out(tx_out), .tx_oe(tx_oe)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    int  t;
    bit  csync, psync;
    bit  rxbits [NS][1024];
    logic [7:0] sent_b [NS][128];
    bit  sent_d [NS][128];
    bit  sent_v [NS][128];

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R3 R4: effective periods-per-bit shift for stream i
    function automatic int sh_of(input int i);
        if (i >= LOWN) return 0;
        case (rate_cfg[2*i +: 2])
            2'b01:   return 1;
            2'b10:   return 2;
            default: return 0;
        endcase
    endfunction

    // R6: sample offset inside a bit
    function automatic int samp_of(input int sh);
        case (sample_cfg)
            2'b01:   return 8 << sh;
            2'b10:   return (16 << sh) - 1;
            default: return 12 << sh;
        endcase
    endfunction

    function automatic int off_of(input int tt, input int sh);
        return tt & ((16 << sh) - 1);
    endfunction

    function automatic int bn_of(input int tt, input int sh);
        return (tt >> 4) >> sh;
    endfunction

    task automatic check_step();
        for (int i = 0; i < NS; i++) begin
            int sh = sh_of(i);
            int bn, off, slot, b, u;
            logic [7:0] eb;
            bit ev, eoe;
            string rtag;
            rtag = (i >= LOWN) ? "R4" : "R3";
            // state-now outputs: request strobe (R8)
            bn  = bn_of(t, sh);
            off = off_of(t, sh);
            ev  = csync && (off == 0) && ((bn & 7) == 0);
            chk("R8 tx_req", int'(tx_req[i]), int'(ev));
            if (ev)
                chk("R8 tx_req_slot", int'(tx_req_slot[7*i +: 7]),
                    ((bn >> 3) + 1) % (128 >> sh));
            // registered outputs reflect the previous state
            u    = (t + FRAME - 1) % FRAME;
            bn   = bn_of(u, sh);
            off  = off_of(u, sh);
            slot = bn >> 3;
            b    = bn & 7;
            ev   = psync && (b == 7) && (off == samp_of(sh));
            chk({rtag, " R7 rx_valid"}, int'(rx_valid[i]), int'(ev));
            if (ev) begin
                for (int j = 0; j < 8; j++) eb[7-j] = rxbits[i][slot*8 + j];
                chk("R5 R6 rx_byte", int'(rx_byte[8*i +: 8]), int'(eb));
                chk("R2 rx_slot", int'(rx_slot[7*i +: 7]), slot);
            end
            eoe = psync && sent_v[i][slot] && sent_d[i][slot] &&
                  !(tz_cfg == 2'b01 && b == 7 && off >= (16 << sh) - EARLY);
            chk((tz_cfg == 2'b01) ? "R11 tx_oe" : "R10 tx_oe", int'(tx_oe[i]), int'(eoe));
            if (eoe)
                chk("R9 R5 tx_out", int'(tx_out[i]), int'(sent_b[i][slot][7-b]));
        end
    endtask

    task automatic drive_step();
        bus_clk_in = (((t + 1) % 16) < 8);
        frame_in   = (((t + 1) % FRAME) < 8);
        for (int i = 0; i < NS; i++) begin
            int sh = sh_of(i);
            int bn = bn_of(t, sh);
            bit v  = rxbits[i][bn];
            logic [7:0] by = 8'($urandom);
            bit dr = ($urandom_range(3, 0) != 0);
            rx_in[i]          = (off_of(t, sh) == samp_of(sh)) ? v : ~v;
            tx_byte[8*i +: 8] = by;
            tx_drive[i]       = dr;
            if (csync && off_of(t, sh) == 0 && (bn & 7) == 0) begin
                int ns = ((bn >> 3) + 1) % (128 >> sh);
                sent_b[i][ns] = by;
                sent_d[i][ns] = dr;
                sent_v[i][ns] = 1'b1;
            end
        end
        psync = csync;
        t = (t + 1) % FRAME;
        if (t == 0) csync = 1'b1;
    endtask

    task automatic run_phase(input logic [2*NS-1:0] rc, input logic [1:0] sc,
                             input logic [1:0] tc, input int ncyc);
        @(negedge clk);
        rst_n = 1'b0; rate_cfg = rc; sample_cfg = sc; tz_cfg = tc;
        bus_clk_in = 1'b0; frame_in = 1'b0; rx_in = '0; tx_byte = '0; tx_drive = '0;
        for (int i = 0; i < NS; i++) begin
            for (int k = 0; k < 1024; k++) rxbits[i][k] = 1'($urandom_range(1, 0));
            for (int k = 0; k < 128; k++) sent_v[i][k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R1 reset rx_valid", int'(rx_valid), 0);
        chk("R1 reset tx_req", int'(tx_req), 0);
        chk("R1 reset tx_oe", int'(tx_oe), 0);
        t = FRAME - 40; csync = 1'b0; psync = 1'b0;
        rst_n = 1'b1;
        drive_step();
        repeat (ncyc) begin
            @(negedge clk);
            check_step();
            drive_step();
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int seed_init;
        int len;
        seed_init = $urandom(32'd20240611);
        len = FRAME + 760;
        rst_n = 1'b0;
        // defaults: full rate, three-quarter sampling, release on edge
        run_phase(8'b00_00_00_00, 2'b00, 2'b00, len);
        // mixed rates (upper streams pinned), mid-bit sampling, early release
        run_phase(8'b01_10_10_01, 2'b01, 2'b01, len);
        // end-of-bit sampling, spare rate code on stream 2, edge release
        run_phase(8'b00_11_01_10, 2'b10, 2'b00, len);
        // spare sample code behaves as three-quarter, random rates
        run_phase(8'($urandom), 2'b11, 2'($urandom), len);
        run_phase(8'($urandom), 2'($urandom), 2'($urandom), len);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule